// File: doc/BRIEF.md
# Sample-Rate High-Band Detector

This block watches the frame-sync strobe of a recovered audio stream and measures the time between strobes in cycles of a reference clock of known frequency. From that interval it works out two things. The first is whether the stream runs in the high-rate band (88.2 kHz or 96 kHz). The second is whether the stream is locked at all, meaning every interval lies inside the 22 kHz to 108 kHz window. The band flag uses two separate thresholds with a hold region between them, so a stream in the gap between the normal and high bands never makes it toggle.

The band output can also report a software-programmed bit, for use when the system clocks itself from a crystal instead of the recovered clock. Measurement and lock tracking keep running in that mode.

The lock tracker is a three-state machine:
- SEARCH has no reference strobe yet.
- ACQUIRE is counting consecutive in-range intervals.
- LOCKED is the locked state.

Its transitions are:
- SEARCH→ACQUIRE on any strobe.
- ACQUIRE→ACQUIRE on an in-range strobe (the count goes up) or an out-of-range strobe (the count goes back to zero).
- ACQUIRE→LOCKED on the strobe that completes the required run.
- LOCKED→ACQUIRE on an out-of-range strobe.
- ACQUIRE→SEARCH and LOCKED→SEARCH when the strobe timeout expires.

Top module: `rate_band_detector`

## Requirements
- R1: While reset is asserted and directly after it, `unlock_o` is 1 and the measured band flag is 0, so with `xtal_mode_i` = 0 `rate_hi_o` reads 0.
- R2: The interval N is the number of `clk_i` rising edges from one sampled strobe to the next. N is in range when floor(REF_HZ/108000) <= N <= floor(REF_HZ/22000). The first strobe after reset or after a timeout only starts a measurement.
- R3: An in-range interval with N <= floor(REF_HZ/88200) sets the band flag, visible from the cycle after the strobe.
- R4: An in-range interval with N >= floor(REF_HZ/54000) clears the band flag, visible from the cycle after the strobe.
- R5: An in-range interval strictly between those two limits leaves the band flag unchanged.
- R6: `unlock_o` falls in the cycle after the strobe that ends LOCK_COUNT consecutive in-range intervals, and stays high until then.
- R7: An out-of-range interval raises `unlock_o` in the cycle after its strobe and restarts the consecutive count from zero.
- R8: If no strobe is sampled for TIMEOUT_CYC = floor(REF_HZ/22000) + MARGIN_CYC edges after the last one, `unlock_o` goes high. The next strobe then only restarts measurement.
- R9: With `xtal_mode_i` = 1, `rate_hi_o` equals `xfs_bit_i` in the same cycle. Measurement, band tracking and lock keep running unchanged.
- R10: Out-of-range intervals and timeouts leave the band flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock of frequency REF_HZ |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_stb_i | input | 1 | Frame-sync strobe, one strobe per frame |
| xtal_mode_i | input | 1 | 1 selects the programmed bit for the band output |
| xfs_bit_i | input | 1 | Programmed band value used in crystal mode |
| rate_hi_o | output | 1 | High-band flag (measured, or programmed in crystal mode) |
| unlock_o | output | 1 | 1 when the stream is not locked or is out of range |

## Verification
The bench builds the block with REF_HZ = 2,160,000, LOCK_COUNT = 4 and MARGIN_CYC = 12. These values put the limits at 20, 24, 40 and 98 cycles and the timeout at 110 cycles. Every threshold, both edges of the valid window and the timeout boundary can therefore be reached with intervals of a few dozen cycles. Random intervals spread over all five regions (too fast, high band, hold gap, low band, too slow or timed out) alternate with crystal-mode changes, so lock loss, relock and the hold region each occur many times in one run.

// File: rtl/rbd_pkg.sv
package rbd_pkg;

    typedef enum logic [1:0] {
        ST_SEARCH  = 2'd0,
        ST_ACQUIRE = 2'd1,
        ST_LOCKED  = 2'd2
    } rbd_state_e;

    // Reference cycles in one frame at the given rate (truncated).
    function automatic int unsigned rbd_cycles(input int unsigned ref_hz,
                                               input int unsigned rate_hz);
        return ref_hz / rate_hz;
    endfunction

endpackage

// File: rtl/rbd_interval_ctr.sv
module rbd_interval_ctr #(
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned TIMEOUT_CYC = 110
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             stb_i,
    output logic [CNT_W-1:0] interval_o,
    output logic             timeout_o
);

    localparam logic [CNT_W-1:0] TO_VAL = CNT_W'(TIMEOUT_CYC);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Counts edges since the last strobe, saturating at the timeout.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (stb_i) begin
            cnt_q <= ONE;
        end else if (cnt_q != TO_VAL) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign interval_o = cnt_q;
    assign timeout_o  = (cnt_q == TO_VAL);

    a_r2_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stb_i |=> (interval_o == ONE));

    a_r8_timeout_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(timeout_o) |-> $past(!stb_i));

endmodule

// File: rtl/rbd_band_cmp.sv
module rbd_band_cmp #(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned LIM_FAST = 20,
    parameter int unsigned LIM_SLOW = 98,
    parameter int unsigned LIM_HI   = 24,
    parameter int unsigned LIM_LO   = 40
) (
    input  logic [CNT_W-1:0] interval_i,
    output logic             in_range_o,
    output logic             at_hi_o,
    output logic             at_lo_o
);

    localparam logic [CNT_W-1:0] C_FAST = CNT_W'(LIM_FAST);
    localparam logic [CNT_W-1:0] C_SLOW = CNT_W'(LIM_SLOW);
    localparam logic [CNT_W-1:0] C_HI   = CNT_W'(LIM_HI);
    localparam logic [CNT_W-1:0] C_LO   = CNT_W'(LIM_LO);

    // Shorter interval means faster rate.
    always_comb begin
        in_range_o = (interval_i >= C_FAST) && (interval_i <= C_SLOW);
        at_hi_o    = (interval_i <= C_HI);
        at_lo_o    = (interval_i >= C_LO);
    end

    a_r5_bands_disjoint: assert property (@(interval_i) !(at_hi_o && at_lo_o))
        else $error("hi and lo bands overlap");

endmodule

// File: rtl/rbd_lock_fsm.sv
module rbd_lock_fsm
    import rbd_pkg::*;
#(
    parameter int unsigned LOCK_COUNT = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic stb_i,
    input  logic timeout_i,
    input  logic in_range_i,
    input  logic at_hi_i,
    input  logic at_lo_i,
    output logic unlock_o,
    output logic band_hi_o
);

    localparam int unsigned GW = $clog2(LOCK_COUNT + 1);
    localparam logic [GW-1:0] LAST_GOOD = GW'(LOCK_COUNT - 1);
    localparam logic [GW-1:0] G_ONE     = GW'(1);

    rbd_state_e      state_q, state_d;
    logic [GW-1:0]   good_q, good_d;
    logic            hi_q;
    logic            measuring;

    assign measuring = stb_i && (state_q != ST_SEARCH);

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_SEARCH;
            good_q  <= '0;
        end else begin
            state_q <= state_d;
            good_q  <= good_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        good_d  = good_q;
        unique case (state_q)
            ST_SEARCH: begin
                if (stb_i) begin
                    state_d = ST_ACQUIRE;
                    good_d  = '0;
                end
            end
            ST_ACQUIRE: begin
                if (stb_i) begin
                    if (!in_range_i) begin
                        good_d = '0;
                    end else if (good_q == LAST_GOOD) begin
                        state_d = ST_LOCKED;
                        good_d  = '0;
                    end else begin
                        good_d = good_q + G_ONE;
                    end
                end else if (timeout_i) begin
                    state_d = ST_SEARCH;
                    good_d  = '0;
                end
            end
            ST_LOCKED: begin
                if (stb_i) begin
                    if (!in_range_i) begin
                        state_d = ST_ACQUIRE;
                        good_d  = '0;
                    end
                end else if (timeout_i) begin
                    state_d = ST_SEARCH;
                end
            end
            default: begin
                state_d = ST_SEARCH;
                good_d  = '0;
            end
        endcase
    end

    // Band flag with hold region
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hi_q <= 1'b0;
        end else if (measuring && in_range_i) begin
            if (at_hi_i) begin
                hi_q <= 1'b1;
            end else if (at_lo_i) begin
                hi_q <= 1'b0;
            end
        end
    end

    // Outputs
    always_comb begin
        unlock_o  = (state_q != ST_LOCKED);
        band_hi_o = hi_q;
    end

    a_r3_set_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (measuring && in_range_i && at_hi_i) |=> band_hi_o);

    a_r4_clear_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (measuring && in_range_i && at_lo_i) |=> !band_hi_o);

    a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (measuring && in_range_i && !at_hi_i && !at_lo_i) |=> $stable(band_hi_o));

    a_r10_oor_keeps_band: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stb_i && !in_range_i) |=> $stable(band_hi_o));

    a_r7_oor_unlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (measuring && !in_range_i) |=> unlock_o);

    a_r8_timeout_unlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (timeout_i && !stb_i && state_q != ST_SEARCH) |=> (unlock_o && state_q == ST_SEARCH));

    a_r6_lock_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(unlock_o) |-> $past(stb_i && in_range_i));

endmodule

// File: rtl/rate_band_detector.sv
module rate_band_detector
    import rbd_pkg::*;
#(
    parameter int unsigned REF_HZ     = 24_576_000,
    parameter int unsigned LOCK_COUNT = 4,
    parameter int unsigned MARGIN_CYC = 128
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic frame_stb_i,
    input  logic xtal_mode_i,
    input  logic xfs_bit_i,
    output logic rate_hi_o,
    output logic unlock_o
);

    localparam int unsigned LIM_FAST    = rbd_cycles(REF_HZ, 108_000);
    localparam int unsigned LIM_HI      = rbd_cycles(REF_HZ, 88_200);
    localparam int unsigned LIM_LO      = rbd_cycles(REF_HZ, 54_000);
    localparam int unsigned LIM_SLOW    = rbd_cycles(REF_HZ, 22_000);
    localparam int unsigned TIMEOUT_CYC = LIM_SLOW + MARGIN_CYC;
    localparam int unsigned CNT_W       = $clog2(TIMEOUT_CYC + 1);

    logic [CNT_W-1:0] interval;
    logic             timeout;
    logic             in_range;
    logic             at_hi;
    logic             at_lo;
    logic             band_hi;

    rbd_interval_ctr #(
        .CNT_W       (CNT_W),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_ctr (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .stb_i      (frame_stb_i),
        .interval_o (interval),
        .timeout_o  (timeout)
    );

    rbd_band_cmp #(
        .CNT_W    (CNT_W),
        .LIM_FAST (LIM_FAST),
        .LIM_SLOW (LIM_SLOW),
        .LIM_HI   (LIM_HI),
        .LIM_LO   (LIM_LO)
    ) u_cmp (
        .interval_i (interval),
        .in_range_o (in_range),
        .at_hi_o    (at_hi),
        .at_lo_o    (at_lo)
    );

    rbd_lock_fsm #(
        .LOCK_COUNT (LOCK_COUNT)
    ) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .stb_i      (frame_stb_i),
        .timeout_i  (timeout),
        .in_range_i (in_range),
        .at_hi_i    (at_hi),
        .at_lo_i    (at_lo),
        .unlock_o   (unlock_o),
        .band_hi_o  (band_hi)
    );

    // Crystal mode: report the programmed bit instead of the measurement.
    assign rate_hi_o = xtal_mode_i ? xfs_bit_i : band_hi;

    a_r9_measure_in_xtal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (xtal_mode_i && frame_stb_i && in_range && at_hi) |=> (band_hi == 1'b1));

endmodule

// File: tb/rate_band_detector_tb.sv
module rate_band_detector_tb;

    localparam int unsigned REF_HZ     = 2_160_000;
    localparam int unsigned LOCK_COUNT = 4;
    localparam int unsigned MARGIN_CYC = 12;

    localparam int L_FAST  = REF_HZ / 108_000;
    localparam int L_HI    = REF_HZ / 88_200;
    localparam int L_LO    = REF_HZ / 54_000;
    localparam int L_SLOW  = REF_HZ / 22_000;
    localparam int TIMEOUT = L_SLOW + MARGIN_CYC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stb = 1'b0;
    logic xtal = 1'b0;
    logic xfs = 1'b0;
    logic rate_hi;
    logic unlock;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model: 0 search, 1 acquire, 2 locked
    int m_state = 0;
    int m_good  = 0;
    bit m_hi    = 1'b0;
    int m_since = 1_000_000;

    always #5 clk = ~clk;

    rate_band_detector #(
        .REF_HZ     (REF_HZ),
        .LOCK_COUNT (LOCK_COUNT),
        .MARGIN_CYC (MARGIN_CYC)
    ) u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .frame_stb_i (stb),
        .xtal_mode_i (xtal),
        .xfs_bit_i   (xfs),
        .rate_hi_o   (rate_hi),
        .unlock_o    (unlock)
    );

    function automatic bit f_in_range(input int n);
        return (n >= L_FAST) && (n <= L_SLOW);
    endfunction

    function automatic bit f_exp_out(input bit x, input bit xb, input bit mh);
        return x ? xb : mh;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_outputs(input string utag, input string htag);
        bit eu;
        bit eh;
        eu = (m_state != 2);
        eh = f_exp_out(xtal, xfs, m_hi);
        check(unlock == eu, utag, unlock, eu);
        check(rate_hi == eh, htag, rate_hi, eh);
    endtask

    // Strobe sampled exactly gap edges after the previous one; check after it.
    task automatic strobe_after(input int gap);
        string utag;
        string htag;
        int n;
        repeat (gap - 1) @(negedge clk);
        m_since += gap - 1;
        n = m_since + 1;
        stb = 1'b1;
        @(negedge clk);
        stb = 1'b0;
        utag = "R6";
        htag = xtal ? "R9" : "R5";
        if (m_state != 0 && m_since >= TIMEOUT) begin
            m_state = 0;
            m_good  = 0;
        end
        if (m_state == 0) begin
            m_state = 1;
            m_good  = 0;
            utag = "R8";
            htag = xtal ? "R9" : "R2";
        end else if (f_in_range(n)) begin
            if (n <= L_HI) begin
                m_hi = 1'b1;
                if (!xtal) htag = "R3";
            end else if (n >= L_LO) begin
                m_hi = 1'b0;
                if (!xtal) htag = "R4";
            end
            if (m_state == 1) begin
                if (m_good == LOCK_COUNT - 1) begin
                    m_state = 2;
                    m_good  = 0;
                end else begin
                    m_good++;
                end
            end
        end else begin
            m_state = 1;
            m_good  = 0;
            utag = "R7";
            if (!xtal) htag = "R10";
        end
        m_since = 0;
        check_outputs(utag, htag);
    endtask

    task automatic idle_cycles(input int m);
        repeat (m) @(negedge clk);
        m_since += m;
        if (m_state != 0 && m_since >= TIMEOUT) begin
            m_state = 0;
            m_good  = 0;
        end
        check_outputs("R8", xtal ? "R9" : "R10");
    endtask

    initial begin
        int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        check_outputs("R1", "R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_outputs("R1", "R1");

        // Directed: acquire at the fast edge of the window, lock after exactly 4 intervals
        strobe_after(5);
        strobe_after(L_FAST);
        strobe_after(L_FAST);
        strobe_after(L_HI);
        strobe_after(L_HI);          // R6: fourth in-range interval locks
        strobe_after(L_HI + 1);      // R5: hold region keeps high
        strobe_after(L_LO - 1);      // R5
        strobe_after(L_FAST - 1);    // R7: one too fast
        strobe_after(L_LO);          // R4 clear
        strobe_after(L_SLOW);
        strobe_after(L_SLOW);
        strobe_after(L_SLOW);        // locked again
        strobe_after(L_SLOW + 1);    // R7: one too slow, band unchanged (R10)
        strobe_after(L_HI);
        strobe_after(L_HI);
        strobe_after(L_HI);
        strobe_after(L_HI);
        idle_cycles(TIMEOUT - 1);    // R8: still locked one edge before timeout
        idle_cycles(1);              // R8: timeout now
        strobe_after(L_LO);          // reference only, band stays high (R2)
        xtal = 1'b1; xfs = 1'b0;
        #1 check(rate_hi == 1'b0, "R9", rate_hi, 0);
        xfs = 1'b1;
        #1 check(rate_hi == 1'b1, "R9", rate_hi, 1);
        xtal = 1'b0;

        // Random mix
        for (int i = 0; i < 600; i++) begin
            int sel;
            int gap;
            sel = int'($urandom_range(0, 99));
            if (sel < 30)      gap = int'($urandom_range(L_FAST, L_HI));
            else if (sel < 55) gap = int'($urandom_range(L_LO, L_SLOW));
            else if (sel < 72) gap = int'($urandom_range(L_HI + 1, L_LO - 1));
            else if (sel < 84) gap = int'($urandom_range(1, L_FAST - 1));
            else               gap = int'($urandom_range(L_SLOW + 1, TIMEOUT + 15));
            if ($urandom_range(0, 9) < 2) begin
                xtal = ~xtal;
                xfs  = 1'($urandom_range(0, 1));
            end
            strobe_after(gap);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150_000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule